// File: doc/BRIEF.md
# Windowed General-Purpose Register File

This block holds the integer registers of a processor core whose procedure calls switch register windows instead of saving registers to memory. The instruction stream always sees 32 architectural registers. The low eight indices name global registers that all code shares. The upper 24 indices name the slots of one physical window, and a current-window pointer selects that window out of several. A call pulse advances the pointer to a fresh window, so the caller's locals stay in place. A return pulse moves the pointer back to the caller's window.

The core reads two operands per cycle through combinational read ports and writes one result per cycle on the rising clock edge. The block counts how deeply windows are nested. It raises a one-cycle overflow flag when a call would go past the deepest window, and a one-cycle underflow flag when a return happens with nothing nested. Trap handling and spilling to memory belong to the surrounding core. With the defaults (8 windows of 24 slots plus 8 globals) the physical array holds 200 words.

Top module: `wrf_top`

## Requirements
- R1: Indices 1 to 7 are globals: a value written to one of them reads back unchanged after any number of calls or returns, and a write made in any window is seen in every other window.
- R2: Index 0 always reads as zero on both read ports, and a write to index 0 has no effect.
- R3: Indices 8 to 31 address slot (index - 8) of the current window, at physical word 8 + cwp*24 + (index - 8). A write in one window is not seen in another window, and a return brings back the caller's values.
- R4: A call alone moves cwp_o to (cwp + 1) mod 8 on the clock edge, and a return alone moves it to (cwp - 1) mod 8. With both or neither asserted, cwp_o stays unchanged and no flag is raised.
- R5: The nesting depth starts at 0, rises by one per call and saturates at 7. A call made at depth 7 sets ovf_o high for exactly the cycle after that edge, and cwp_o still advances.
- R6: A return made at depth 0 sets unf_o high for exactly the cycle after that edge, and cwp_o still moves back. Depth stays at 0.
- R7: A read of the physical word being written in the same cycle returns the stored old value when byp_en_i is 0, and the write data when byp_en_i is 1. A bypassed write to index 0 still reads as zero.
- R8: A synchronous reset sets cwp_o, the depth, ovf_o and unf_o to zero on the clock edge. The register contents are kept.
- R9: The two read ports decode their indices independently, so they return two different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Call pulse: advance to the next window |
| ret_i | input | 1 | Return pulse: go back to the previous window |
| byp_en_i | input | 1 | Forward same-cycle write data to the reads |
| we_i | input | 1 | Write enable |
| waddr_i | input | 5 | Architectural index written |
| wdata_i | input | 32 | Write data |
| raddr_a_i | input | 5 | Architectural index read on port A |
| rdata_a_o | output | 32 | Read data, port A |
| raddr_b_i | input | 5 | Architectural index read on port B |
| rdata_b_o | output | 32 | Read data, port B |
| cwp_o | output | 3 | Current window pointer |
| ovf_o | output | 1 | Window overflow flag, one cycle |
| unf_o | output | 1 | Window underflow flag, one cycle |

## Verification
Read data depends only on the current state and inputs, so the bench samples it a moment after changing the read index. A write, a call or a return takes effect on the next rising edge. The bench changes inputs at the falling edge and samples one falling edge later, after exactly one register stage. The flags and the new pointer are registered from the call or return edge, so they are checked in that same following half-cycle. The flags are checked again one cycle later to confirm that they have dropped. A same-cycle read during a write is sampled before the edge, to tell the old value from the bypassed value.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2
    } win_op_e;

    // Simultaneous call and return cancel each other out.
    function automatic win_op_e decode_op(input logic call, input logic ret);
        if (call && !ret)
            return OP_CALL;
        else if (ret && !call)
            return OP_RET;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CW = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  win_op_e       op,
    output logic [CW-1:0] cwp,
    output logic          ovf,
    output logic          unf
);

    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic [CW-1:0] depth;
        logic          ovf;
        logic          unf;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ovf = 1'b0;
        ctl_d.unf = 1'b0;
        case (op)
            OP_CALL: begin
                ctl_d.cwp = (ctl_q.cwp == LAST) ? '0 : ctl_q.cwp + 1'b1;
                if (ctl_q.depth == LAST)
                    ctl_d.ovf = 1'b1;
                else
                    ctl_d.depth = ctl_q.depth + 1'b1;
            end
            OP_RET: begin
                ctl_d.cwp = (ctl_q.cwp == '0) ? LAST : ctl_q.cwp - 1'b1;
                if (ctl_q.depth == '0)
                    ctl_d.unf = 1'b1;
                else
                    ctl_d.depth = ctl_q.depth - 1'b1;
            end
            default: ;
        endcase
        if (rst)
            ctl_d = '0;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign cwp = ctl_q.cwp;
    assign ovf = ctl_q.ovf;
    assign unf = ctl_q.unf;

endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
    parameter int NGLB = 8,
    parameter int NLOC = 24,
    parameter int AW   = 5,
    parameter int CW   = 3,
    parameter int PW   = 8
) (
    input  logic [AW-1:0] idx,
    input  logic [CW-1:0] cwp,
    output logic [PW-1:0] phys
);

    always_comb begin
        if (int'(idx) < NGLB)
            phys = PW'(idx);
        else
            phys = PW'(NGLB) + PW'(cwp) * PW'(NLOC) + PW'(idx) - PW'(NGLB);
    end

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DEPTH = 200,
    parameter int PW    = 8,
    parameter int W     = 32,
    parameter int NRD   = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] wphys,
    input  logic [W-1:0]  wdata,
    input  logic          byp_en,
    input  logic [PW-1:0] rphys [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] mem_q [DEPTH];
    logic         wr_live;

    // Physical word 0 is the hard-wired zero register.
    assign wr_live = we && (wphys != '0);

    always_ff @(posedge clk) begin
        if (wr_live)
            mem_q[wphys] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rphys[p] == '0)
                rdata[p] = '0;
            else if (byp_en && wr_live && (wphys == rphys[p]))
                rdata[p] = wdata;
            else
                rdata[p] = mem_q[rphys[p]];
        end
    end

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NGLB = 8,
    parameter int NARCH = 32,
    parameter int W    = 32,
    localparam int NLOC  = NARCH - NGLB,
    localparam int DEPTH = NGLB + NWIN * NLOC,
    localparam int AW    = $clog2(NARCH),
    localparam int CW    = $clog2(NWIN),
    localparam int PW    = $clog2(DEPTH),
    localparam int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          byp_en_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_a_i,
    output logic [W-1:0]  rdata_a_o,
    input  logic [AW-1:0] raddr_b_i,
    output logic [W-1:0]  rdata_b_o,
    output logic [CW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);

    logic [AW-1:0] idx_all  [NPORT];
    logic [PW-1:0] phys_all [NPORT];
    logic [PW-1:0] rd_phys  [2];
    logic [W-1:0]  rd_data  [2];

    wrf_win_ctrl #(.NWIN(NWIN)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .op  (decode_op(call_i, ret_i)),
        .cwp (cwp_o),
        .ovf (ovf_o),
        .unf (unf_o)
    );

    // Port 0 is the write port, ports 1 and 2 the read ports.
    assign idx_all[0] = waddr_i;
    assign idx_all[1] = raddr_a_i;
    assign idx_all[2] = raddr_b_i;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_addr_map #(
            .NGLB(NGLB), .NLOC(NLOC), .AW(AW), .CW(CW), .PW(PW)
        ) u_map (
            .idx  (idx_all[p]),
            .cwp  (cwp_o),
            .phys (phys_all[p])
        );
    end

    assign rd_phys[0] = phys_all[1];
    assign rd_phys[1] = phys_all[2];

    wrf_store #(.DEPTH(DEPTH), .PW(PW), .W(W), .NRD(2)) u_store (
        .clk    (clk),
        .we     (we_i),
        .wphys  (phys_all[0]),
        .wdata  (wdata_i),
        .byp_en (byp_en_i),
        .rphys  (rd_phys),
        .rdata  (rd_data)
    );

    assign rdata_a_o = rd_data[0];
    assign rdata_b_o = rd_data[1];

endmodule

// File: rtl/wrf_top_chk.sv
module wrf_top_chk #(
    parameter int NWIN = 8,
    parameter int W    = 32,
    parameter int AW   = 5,
    localparam int CW  = $clog2(NWIN)
) (
    input logic          clk,
    input logic          rst,
    input logic          call_i,
    input logic          ret_i,
    input logic [AW-1:0] raddr_a_i,
    input logic [W-1:0]  rdata_a_o,
    input logic [AW-1:0] raddr_b_i,
    input logic [W-1:0]  rdata_b_o,
    input logic [CW-1:0] cwp_o,
    input logic          ovf_o,
    input logic          unf_o
);

    localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

    // R2
    zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr_a_i == '0) |-> (rdata_a_o == '0));

    // R2
    zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
        (raddr_b_i == '0) |-> (rdata_b_o == '0));

    // R4
    cwp_call_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i) |=>
            (cwp_o == (($past(cwp_o) == LAST) ? '0 : $past(cwp_o) + 1'b1)));

    // R4
    cwp_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i) |=>
            (cwp_o == (($past(cwp_o) == '0) ? LAST : $past(cwp_o) - 1'b1)));

    // R4
    cwp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (call_i == ret_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));

    // R5
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> ($past(call_i) && !$past(ret_i)));

    // R6
    unf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> ($past(ret_i) && !$past(call_i)));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ((cwp_o == '0) && !ovf_o && !unf_o));

endmodule

bind wrf_top wrf_top_chk #(.NWIN(NWIN), .W(W), .AW(AW)) u_chk (.*);

// File: tb/wrf_top_tb_top.sv
module wrf_top_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 1'b0, ret_i = 1'b0, byp_en_i = 1'b0, we_i = 1'b0;
    logic [4:0]  waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_a_o, rdata_b_o;
    logic [2:0]  cwp_o;
    logic        ovf_o, unf_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    wrf_top dut_i (
        .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
        .byp_en_i(byp_en_i), .we_i(we_i), .waddr_i(waddr_i),
        .wdata_i(wdata_i), .raddr_a_i(raddr_a_i), .rdata_a_o(rdata_a_o),
        .raddr_b_i(raddr_b_i), .rdata_b_o(rdata_b_o), .cwp_o(cwp_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    task automatic wr(input logic [4:0] i, input logic [31:0] v);
        we_i = 1'b1; waddr_i = i; wdata_i = v;
        step();
        we_i = 1'b0;
    endtask

    task automatic do_call();
        call_i = 1'b1;
        step();
        call_i = 1'b0;
    endtask

    task automatic do_ret();
        ret_i = 1'b1;
        step();
        ret_i = 1'b0;
    endtask

    task automatic rda(input logic [4:0] i, output logic [31:0] v);
        raddr_a_i = i;
        #1 v = rdata_a_o;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R8 reset cwp", 32'(cwp_o), 0);
        chk("R8 reset ovf", 32'(ovf_o), 0);
        chk("R8 reset unf", 32'(unf_o), 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(5'd0, 32'hDEAD_BEEF);
        rda(5'd0, v);
        chk("R2 zero port A", v, 0);
        raddr_b_i = 5'd0;
        #1 chk("R2 zero port B", rdata_b_o, 0);
    endtask

    task automatic t_globals();
        wr(5'd3, 32'h0000_0033);
        wr(5'd7, 32'h0000_0077);
        do_call();
        raddr_a_i = 5'd3; raddr_b_i = 5'd7;
        #1;
        chk("R1 global 3 in window 1", rdata_a_o, 32'h33);
        chk("R9 port B global 7", rdata_b_o, 32'h77);
        wr(5'd3, 32'h0000_003A);
        do_ret();
        raddr_a_i = 5'd3;
        #1 chk("R1 global write seen after return", rdata_a_o, 32'h3A);
    endtask

    task automatic t_windows();
        logic [31:0] v;
        wr(5'd8,  32'hA000_0008);
        wr(5'd31, 32'hA000_0031);
        do_call();
        wr(5'd8, 32'hB000_0008);
        rda(5'd8, v);
        chk("R3 callee slot 8", v, 32'hB000_0008);
        do_ret();
        raddr_a_i = 5'd8; raddr_b_i = 5'd31;
        #1;
        chk("R3 caller slot 8 restored", rdata_a_o, 32'hA000_0008);
        chk("R9 port B caller slot 31", rdata_b_o, 32'hA000_0031);
    endtask

    task automatic t_cwp();
        do_call();
        chk("R4 call 0->1", 32'(cwp_o), 1);
        do_call();
        chk("R4 call 1->2", 32'(cwp_o), 2);
        call_i = 1'b1; ret_i = 1'b1;
        step();
        call_i = 1'b0; ret_i = 1'b0;
        chk("R4 both hold cwp", 32'(cwp_o), 2);
        chk("R4 both no flag", 32'({ovf_o, unf_o}), 0);
        do_ret();
        chk("R4 ret 2->1", 32'(cwp_o), 1);
        do_ret();
        chk("R4 ret 1->0", 32'(cwp_o), 0);
        chk("R6 no underflow at depth 1", 32'(unf_o), 0);
    endtask

    task automatic t_overflow();
        logic [31:0] v;
        do_reset();
        wr(5'd8, 32'hC000_00C0);
        for (int k = 1; k <= 7; k++) begin
            do_call();
            chk("R5 no overflow below depth 7", 32'(ovf_o), 0);
        end
        chk("R4 cwp at 7", 32'(cwp_o), 7);
        do_call();
        chk("R5 overflow flag", 32'(ovf_o), 1);
        chk("R5 cwp wraps to 0", 32'(cwp_o), 0);
        rda(5'd8, v);
        chk("R3 wrapped window 0 slot 8", v, 32'hC000_00C0);
        step();
        chk("R5 overflow one cycle", 32'(ovf_o), 0);
        do_ret();
        chk("R5 depth saturated, ret no underflow", 32'(unf_o), 0);
        chk("R4 ret wraps 0->7", 32'(cwp_o), 7);
    endtask

    task automatic t_underflow();
        do_reset();
        do_ret();
        chk("R6 underflow flag", 32'(unf_o), 1);
        chk("R6 cwp moves to 7", 32'(cwp_o), 7);
        step();
        chk("R6 underflow one cycle", 32'(unf_o), 0);
        do_call();
        chk("R6 call after underflow cwp", 32'(cwp_o), 0);
        chk("R5 no overflow after underflow", 32'(ovf_o), 0);
    endtask

    task automatic t_bypass();
        byp_en_i = 1'b0;
        wr(5'd5, 32'h0000_0055);
        we_i = 1'b1; waddr_i = 5'd5; wdata_i = 32'h0000_0066; raddr_a_i = 5'd5;
        #1 chk("R7 no bypass old value", rdata_a_o, 32'h55);
        step();
        we_i = 1'b0;
        #1 chk("R7 new value after edge", rdata_a_o, 32'h66);
        byp_en_i = 1'b1;
        we_i = 1'b1; waddr_i = 5'd5; wdata_i = 32'h0000_0077;
        #1 chk("R7 bypass forwards", rdata_a_o, 32'h77);
        step();
        we_i = 1'b1; waddr_i = 5'd0; wdata_i = 32'h0000_0099; raddr_b_i = 5'd0;
        #1 chk("R7 bypass to index 0 reads zero", rdata_b_o, 0);
        step();
        we_i = 1'b0; byp_en_i = 1'b0;
    endtask

    task automatic t_keep();
        logic [31:0] v;
        do_reset();
        do_call(); do_call(); do_call();
        wr(5'd10, 32'h5EED_0010);
        wr(5'd2,  32'h5EED_0002);
        do_reset();
        chk("R8 reset clears cwp", 32'(cwp_o), 0);
        do_call(); do_call(); do_call();
        rda(5'd10, v);
        chk("R8 window data kept", v, 32'h5EED_0010);
        rda(5'd2, v);
        chk("R8 global data kept", v, 32'h5EED_0002);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step();
        t_reset();
        t_zero();
        t_globals();
        t_windows();
        t_cwp();
        t_overflow();
        t_underflow();
        t_bypass();
        t_keep();
        step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule